// File: doc/BRIEF.md
# PROM and I/O External Bus Access Timer

This block sequences single accesses to the boot-memory (PROM) area and the peripheral I/O area of an external asynchronous memory bus. A host hands it one access at a time on a valid/ready request port. The block works out which area the address falls in and, for the PROM area, which of its two chip selects to drive. It then holds the strobes for a programmed number of wait cycles and returns a one-cycle response that carries an error flag.

A single 32-bit configuration register sets the timing. The two PROM wait fields count in steps of two cycles, and the I/O wait field counts one cycle per step. Each area has its own enable for stretching the cycle with an external active-low ready pin, and that pin can pass through a synchroniser. A bus-error enable lets an external active-low error pin cut an access short. A PROM write is refused unless PROM writes are enabled, and an I/O access is refused unless the I/O area is enabled.

Request back-pressure: `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the host must hold `req_addr` and `req_write` steady until then. The response is a single-cycle `rsp_valid` pulse and cannot be stalled. `req_ready` returns high in the cycle after the pulse.

Top module: `promio_bus_seq`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x0000000F: PROM read wait field = 15, and all other fields and enables are 0. `req_ready` is 1, and all strobes (`prom_cs_n`, `io_sel_n`, `oe_n`, `we_n`) are high.
- R2: Address nibble [31:28] of 0 or 1 selects the PROM area. A PROM read holds its strobes for 2*F+1 cycles, where F is cfg[3:0]. A PROM write does the same with F = cfg[7:4]. `rsp_valid` rises in the cycle after the strobes are released.
- R3: Address nibble [31:28] of 2 selects the I/O area. An I/O access holds its strobes for F+1 cycles, where F is cfg[11:8].
- R4: For a PROM access, `prom_cs_n[b]` goes low, where b is the address bit at position 13+N. N is cfg[15:12], and N=0 uses bit 28. An I/O access drives `io_sel_n` low instead. At most one select is low at a time. `oe_n` is low for reads and `we_n` is low for writes, never both together, and only while a select is active.
- R5: When the area's ready enable is set (cfg[18] for PROM, cfg[19] for I/O), the access does not end before the wait count expires and `bus_rdy_n` has been seen low. When the enable is clear, `bus_rdy_n` has no effect.
- R6: With cfg[21] = 0, `bus_rdy_n` is used in the same cycle it is low. With cfg[21] = 1, it passes through two flops, so it is seen two cycles later.
- R7: Three kinds of access finish with `rsp_valid` and `rsp_err` in the cycle after acceptance, with no strobe driven: a PROM write while cfg[16] = 0, an I/O access while cfg[17] = 0, and any address with nibble 3 to 15.
- R8: With cfg[20] = 1, `bus_err_n` low during an access ends it at that edge and gives an error response, taking priority over normal completion. With cfg[20] = 0, `bus_err_n` is ignored.
- R9: `rsp_valid` lasts exactly one cycle. `req_ready` is low from acceptance through the response cycle.
- R10: The 22 configuration bits read back as written, and bits [31:22] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block idle, able to take a request |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Access complete (one cycle) |
| rsp_err | output | 1 | Access completed with error |
| prom_cs_n | output | 2 | PROM chip selects, active low |
| io_sel_n | output | 1 | I/O area select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| bus_rdy_n | input | 1 | External ready, active low |
| bus_err_n | input | 1 | External bus error, active low |

## Verification
The hardest case to reach from the ports is the interaction of ready stretching, the synchroniser delay and a bus error that arrives on the very edge where the wait count would otherwise complete. The bench handles this by driving `bus_rdy_n` and `bus_err_n` low at strobe-cycle indices it picks per access, in the middle of the cycle. It does this over random configurations where the wait count, the ready enable, the synchroniser mode and the error enable all vary. A reference function computes the resulting strobe length and error flag. Directed accesses add the extreme wait counts, each bank-size decode edge, and the blocked and unmapped cases.

// File: rtl/promio_pkg.sv
package promio_pkg;

  localparam int WS_W          = 4;
  localparam int CNT_W         = WS_W + 1;
  localparam int BANK_BASE_LOG = 13;
  localparam int BANK_MAX_BIT  = 28;
  localparam int BIDX_W        = 5;

  typedef enum logic [1:0] {
    AREA_NONE = 2'd0,
    AREA_PROM = 2'd1,
    AREA_IO   = 2'd2
  } area_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_ACK    = 2'd2
  } seq_state_e;

  // Packed MSB first: prom_rd_ws lands in bits [3:0].
  typedef struct packed {
    logic            async_rdy;
    logic            err_en;
    logic            io_rdy_en;
    logic            prom_rdy_en;
    logic            io_en;
    logic            prom_wen;
    logic [WS_W-1:0] bank_sz;
    logic [WS_W-1:0] io_ws;
    logic [WS_W-1:0] prom_wr_ws;
    logic [WS_W-1:0] prom_rd_ws;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/promio_cfg_regs.sv
module promio_cfg_regs
  import promio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output cfg_t              cfg
);

  localparam int PAD_W = DATA_W - CFG_W;

  function automatic cfg_t reset_value();
    cfg_t v;
    v            = '0;
    v.prom_rd_ws = '1;
    return v;
  endfunction

  cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= reset_value();
    end else if (we) begin
      cfg_q <= cfg_t'(wdata[CFG_W-1:0]);
    end
  end

  assign cfg   = cfg_q;
  assign rdata = {{PAD_W{1'b0}}, cfg_q};

endmodule

// File: rtl/promio_decode.sv
module promio_decode
  import promio_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  cfg_t              cfg,
  output area_e             area,
  output logic              bank_sel,
  output logic [CNT_W-1:0]  wait_cnt,
  output logic              rdy_en,
  output logic              blocked
);

  localparam int REGION_W = 4;

  logic [REGION_W-1:0] region;
  logic [BIDX_W-1:0]   bank_bit;

  assign region = addr[ADDR_W-1 -: REGION_W];

  always_comb begin
    unique case (region)
      4'd0, 4'd1: area = AREA_PROM;
      4'd2:       area = AREA_IO;
      default:    area = AREA_NONE;
    endcase
  end

  // Exponential bank size: 8 KiB * 2^N, N = 0 meaning the largest bank.
  always_comb begin
    if (cfg.bank_sz == '0) begin
      bank_bit = BIDX_W'(BANK_MAX_BIT);
    end else begin
      bank_bit = BIDX_W'(BANK_BASE_LOG) + BIDX_W'(cfg.bank_sz);
    end
  end

  assign bank_sel = addr[bank_bit];

  always_comb begin
    wait_cnt = '0;
    rdy_en   = 1'b0;
    blocked  = 1'b1;
    unique case (area)
      AREA_PROM: begin
        wait_cnt = write ? {cfg.prom_wr_ws, 1'b0} : {cfg.prom_rd_ws, 1'b0};
        rdy_en   = cfg.prom_rdy_en;
        blocked  = write && !cfg.prom_wen;
      end
      AREA_IO: begin
        wait_cnt = {1'b0, cfg.io_ws};
        rdy_en   = cfg.io_rdy_en;
        blocked  = !cfg.io_en;
      end
      default: begin
        blocked = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/promio_rdy_sync.sv
module promio_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_mode,
  input  logic rdy_n_in,
  output logic rdy_n_out
);

  generate
    if (STAGES > 0) begin : g_sync
      logic [STAGES-1:0] chain;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          chain <= '1;
        end else begin
          chain[0] <= rdy_n_in;
          for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
          end
        end
      end

      assign rdy_n_out = async_mode ? chain[STAGES-1] : rdy_n_in;
    end else begin : g_direct
      logic unused_ok;
      assign unused_ok = clk ^ rst_n ^ async_mode;
      assign rdy_n_out = rdy_n_in;
    end
  endgenerate

endmodule

// File: rtl/promio_fsm.sv
module promio_fsm
  import promio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  area_e            dec_area,
  input  logic             dec_bank,
  input  logic [CNT_W-1:0] dec_wait,
  input  logic             dec_rdy_en,
  input  logic             dec_blocked,
  input  logic             err_en,
  input  logic             rdy_n,
  input  logic             err_n,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [1:0]       prom_cs_n,
  output logic             io_sel_n,
  output logic             oe_n,
  output logic             we_n
);

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  area_e            area_q;
  logic             bank_q;
  logic             wr_q;
  logic             rdy_en_q;
  logic             err_q;
  logic             accept;
  logic             in_access;

  assign accept    = req_valid && (st_q == ST_IDLE);
  assign in_access = (st_q == ST_ACCESS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      area_q   <= AREA_NONE;
      bank_q   <= 1'b0;
      wr_q     <= 1'b0;
      rdy_en_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (dec_blocked) begin
              st_q  <= ST_ACK;
              err_q <= 1'b1;
            end else begin
              st_q     <= ST_ACCESS;
              cnt_q    <= dec_wait;
              area_q   <= dec_area;
              bank_q   <= dec_bank;
              wr_q     <= req_write;
              rdy_en_q <= dec_rdy_en;
              err_q    <= 1'b0;
            end
          end
        end
        ST_ACCESS: begin
          if (err_en && !err_n) begin
            st_q  <= ST_ACK;
            err_q <= 1'b1;
          end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!rdy_en_q || !rdy_n) begin
            st_q <= ST_ACK;
          end
        end
        ST_ACK: begin
          st_q   <= ST_IDLE;
          area_q <= AREA_NONE;
        end
        default: begin
          st_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready    = (st_q == ST_IDLE);
  assign rsp_valid    = (st_q == ST_ACK);
  assign rsp_err      = rsp_valid && err_q;
  assign prom_cs_n[0] = !(in_access && area_q == AREA_PROM && !bank_q);
  assign prom_cs_n[1] = !(in_access && area_q == AREA_PROM && bank_q);
  assign io_sel_n     = !(in_access && area_q == AREA_IO);
  assign oe_n         = !(in_access && !wr_q);
  assign we_n         = !(in_access && wr_q);

endmodule

// File: rtl/promio_bus_seq.sv
module promio_bus_seq
  import promio_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [1:0]        prom_cs_n,
  output logic              io_sel_n,
  output logic              oe_n,
  output logic              we_n,
  input  logic              bus_rdy_n,
  input  logic              bus_err_n
);

  cfg_t             cfg;
  area_e            dec_area;
  logic             dec_bank;
  logic [CNT_W-1:0] dec_wait;
  logic             dec_rdy_en;
  logic             dec_blocked;
  logic             rdy_n_s;

  promio_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  promio_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (req_addr),
    .write    (req_write),
    .cfg      (cfg),
    .area     (dec_area),
    .bank_sel (dec_bank),
    .wait_cnt (dec_wait),
    .rdy_en   (dec_rdy_en),
    .blocked  (dec_blocked)
  );

  promio_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_mode (cfg.async_rdy),
    .rdy_n_in   (bus_rdy_n),
    .rdy_n_out  (rdy_n_s)
  );

  promio_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .dec_area    (dec_area),
    .dec_bank    (dec_bank),
    .dec_wait    (dec_wait),
    .dec_rdy_en  (dec_rdy_en),
    .dec_blocked (dec_blocked),
    .err_en      (cfg.err_en),
    .rdy_n       (rdy_n_s),
    .err_n       (bus_err_n),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .prom_cs_n   (prom_cs_n),
    .io_sel_n    (io_sel_n),
    .oe_n        (oe_n),
    .we_n        (we_n)
  );

endmodule

// File: rtl/promio_checker.sv
module promio_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [1:0]        prom_cs_n,
  input logic              io_sel_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              bus_err_n
);

  logic [3:0] region;
  logic       take;
  logic       strobing;

  assign region   = req_addr[ADDR_W-1 -: 4];
  assign take     = req_valid && req_ready;
  assign strobing = !oe_n || !we_n;

  AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~prom_cs_n, ~io_sel_n})); // R4

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n)); // R4

  AST_STROBE_HAS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    strobing |-> ((prom_cs_n != 2'b11) || !io_sel_n)); // R4

  AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_write && region < 4'd2 && !cfg_rdata[16])
      |=> (rsp_valid && rsp_err && we_n)); // R7

  AST_IO_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && region == 4'd2 && !cfg_rdata[17])
      |=> (rsp_valid && rsp_err && io_sel_n)); // R7

  AST_ERR_TERMINATES: assert property (@(posedge clk) disable iff (!rst_n)
    (strobing && cfg_rdata[20] && !bus_err_n) |=> (rsp_valid && rsp_err)); // R8

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (strobing || rsp_valid) |-> !req_ready); // R9

endmodule

bind promio_bus_seq promio_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_rdata (cfg_rdata),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .prom_cs_n (prom_cs_n),
  .io_sel_n  (io_sel_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .bus_err_n (bus_err_n)
);

// File: tb/promio_bus_seq_tb_top.sv
`timescale 1ns/1ps
module promio_bus_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_err;
  logic [1:0]  prom_cs_n;
  logic        io_sel_n;
  logic        oe_n;
  logic        we_n;
  logic        bus_rdy_n = 1'b1;
  logic        bus_err_n = 1'b1;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] cur_cfg;

  // results of the last access
  int         got_lat;
  int         got_strb;
  logic       got_err;
  logic [4:0] got_pins;
  logic       got_rdy_in_rsp;
  logic       got_rdy_after;

  always #5 clk = ~clk;

  promio_bus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .prom_cs_n(prom_cs_n), .io_sel_n(io_sel_n),
    .oe_n(oe_n), .we_n(we_n), .bus_rdy_n(bus_rdy_n), .bus_err_n(bus_err_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we  = 1'b0;
    cur_cfg = v & 32'h003F_FFFF;
  endtask

  // Reference model of one access.
  task automatic expect_access(input logic [31:0] cfg, input logic [31:0] a,
                               input logic wr, input int t_r, input int t_e,
                               output int s, output logic err,
                               output logic [4:0] pins, output string tag);
    logic [3:0] region;
    bit prom, io, blocked, rdy_en;
    int w, e, bit_i;
    logic [1:0] cs;
    region  = a[31:28];
    prom    = region < 4'd2;
    io      = region == 4'd2;
    blocked = !(prom || io) || (prom && wr && !cfg[16]) || (io && !cfg[17]);
    if (blocked) begin
      s = 0; err = 1'b1; pins = 5'h1F; tag = "R7";
      return;
    end
    w      = prom ? 2 * int'(wr ? cfg[7:4] : cfg[3:0]) : int'(cfg[11:8]);
    rdy_en = prom ? cfg[18] : cfg[19];
    e      = w;
    tag    = prom ? "R2" : "R3";
    if (rdy_en) begin
      tag = cfg[21] ? "R6" : "R5";
      if (t_r + (cfg[21] ? 2 : 0) > e) e = t_r + (cfg[21] ? 2 : 0);
    end
    if (cfg[20] && t_e >= 0 && t_e <= e) begin
      s = t_e + 1; err = 1'b1; tag = "R8";
    end else begin
      s = e + 1; err = 1'b0;
    end
    if (prom) begin
      bit_i = (cfg[15:12] == 4'd0) ? 28 : 13 + int'(cfg[15:12]);
      cs    = a[bit_i] ? 2'b01 : 2'b10;
      pins  = {cs, 1'b1, wr, !wr};
    end else begin
      pins = {2'b11, 1'b0, wr, !wr};
    end
  endtask

  task automatic do_access(input logic [31:0] a, input logic wr,
                           input int t_r, input int t_e);
    int n;
    @(negedge clk);
    req_addr  = a;
    req_write = wr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got_pins  = {prom_cs_n, io_sel_n, oe_n, we_n};
    got_strb  = 0;
    n = 0;
    while (!rsp_valid && n < 200) begin
      if (n == t_r) bus_rdy_n = 1'b0;
      if (n == t_e) bus_err_n = 1'b0;
      if (!oe_n || !we_n) got_strb++;
      @(negedge clk);
      n++;
    end
    got_lat        = n;
    got_err        = rsp_err;
    got_rdy_in_rsp = req_ready;
    @(negedge clk);
    got_rdy_after  = req_ready;
    bus_rdy_n = 1'b1;
    bus_err_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_and_check(input logic [31:0] a, input logic wr,
                               input int t_r, input int t_e);
    int s;
    logic e;
    logic [4:0] p;
    string tag;
    expect_access(cur_cfg, a, wr, t_r, t_e, s, e, p, tag);
    do_access(a, wr, t_r, t_e);
    check(got_lat == s,  tag, "response latency", got_lat, s);
    check(got_strb == s, tag, "strobe cycles", got_strb, s);
    check(got_err == e,  tag, "error flag", {31'd0, got_err}, {31'd0, e});
    check(got_pins == p, "R4", "pins in first cycle", {27'd0, got_pins}, {27'd0, p});
    check(!got_rdy_in_rsp && got_rdy_after, "R9", "req_ready around response",
          {30'd0, got_rdy_in_rsp, got_rdy_after}, 32'd1);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_cfg = 32'h0000_000F;

    // R1 reset state
    check(cfg_rdata == 32'h0000_000F, "R1", "cfg reset value", cfg_rdata, 32'h0000_000F);
    check(req_ready == 1'b1, "R1", "req_ready at reset", {31'd0, req_ready}, 32'd1);
    check({prom_cs_n, io_sel_n, oe_n, we_n, rsp_valid} == 6'b111110, "R1", "pins at reset",
          {26'd0, prom_cs_n, io_sel_n, oe_n, we_n, rsp_valid}, 32'h3E);

    // R2 boot read uses 30 wait cycles, bank bit 28
    run_and_check(32'h0000_0100, 1'b0, -1, -1);
    run_and_check(32'h1000_0000, 1'b0, -1, -1);

    // R10 read-back of all fields, upper bits zero
    write_cfg(32'hFFFF_FFFF);
    check(cfg_rdata == 32'h003F_FFFF, "R10", "cfg readback", cfg_rdata, 32'h003F_FFFF);
    write_cfg(32'h0001_2C35);
    check(cfg_rdata == 32'h0001_2C35, "R10", "cfg readback", cfg_rdata, 32'h0001_2C35);

    // R4 bank-size decode edges: N=1 -> bit 14, N=11 -> bit 24
    write_cfg(32'h0003_1F00);
    run_and_check(32'h0000_4000, 1'b0, -1, -1);
    run_and_check(32'h0000_2000, 1'b0, -1, -1);
    write_cfg(32'h0003_BF00);
    run_and_check(32'h0100_0000, 1'b0, -1, -1);
    run_and_check(32'h0080_0000, 1'b0, -1, -1);

    // R2 PROM write at max, R3 I/O linear max
    write_cfg(32'h0003_0FF0);
    run_and_check(32'h0000_0040, 1'b1, -1, -1);
    run_and_check(32'h2000_0010, 1'b0, -1, -1);
    run_and_check(32'h2000_0010, 1'b1, -1, -1);

    // R7 blocked write, disabled I/O, unmapped
    write_cfg(32'h0000_0000);
    run_and_check(32'h0000_0000, 1'b1, -1, -1);
    run_and_check(32'h2000_0000, 1'b0, -1, -1);
    run_and_check(32'h3000_0000, 1'b0, -1, -1);
    run_and_check(32'hF000_0000, 1'b1, -1, -1);

    // R5 ready stretch sync, R6 async delays by two
    write_cfg(32'h0004_0000);
    run_and_check(32'h0000_0000, 1'b0, 5, -1);
    write_cfg(32'h0024_0000);
    run_and_check(32'h0000_0000, 1'b0, 5, -1);
    // R5 ready ignored when area enable clear
    write_cfg(32'h0002_0203);
    run_and_check(32'h2000_0000, 1'b0, 9, -1);

    // R8 error terminates when enabled, ignored otherwise
    write_cfg(32'h0010_000F);
    run_and_check(32'h0000_0000, 1'b0, -1, 2);
    write_cfg(32'h0000_000F);
    run_and_check(32'h0000_0000, 1'b0, -1, 2);
    // R8 error on the completing edge wins
    write_cfg(32'h0010_0002);
    run_and_check(32'h0000_0000, 1'b0, -1, 4);

    // constrained random
    for (int i = 0; i < 160; i++) begin
      logic [31:0] c, a;
      logic        wr;
      int          tr, te;
      c  = $urandom() & 32'h003F_FFFF;
      if ($urandom_range(0, 3) != 0) c[17:16] = 2'b11;
      a  = $urandom();
      a[31:28] = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(3, 15))
                                              : 4'($urandom_range(0, 2));
      wr = 1'($urandom());
      tr = $urandom_range(0, 35);
      te = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 40) : -1;
      write_cfg(c);
      run_and_check(a, wr, tr, te);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule